// File: doc/BRIEF.md
# Asynchronous Pseudo-SRAM Bus Controller

This block sits between a synchronous host and a 2M x 16 pseudo-static RAM run over its asynchronous SRAM-style bus. The host issues single-word reads and writes through a valid/ready request port. The controller turns each accepted request into a self-timed memory cycle, with chip enable, output enable, write enable and the two byte-lane strobes driven from registers. Read data comes back on a response strobe. Every interval is counted in system clock cycles, and each count is a parameter: the power-up hold, the read access time, the write-pulse width and the chip-enable recovery gap.

The memory comes out of power-up in its asynchronous mode, so no configuration step is needed. After reset the controller keeps chip enable high and refuses requests until the power-up hold has run out. The address-valid strobe is tied low so that the address flows through for the whole cycle. The memory clock is parked low. The memory's wait output is not connected, because asynchronous cycles never look at it.

Back-pressure rules: a request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. Once the host raises valid, it must hold valid and all request fields stable until that edge. Ready stays low from acceptance until the recovery gap after the cycle has ended. The response strobe cannot be stalled: it is high for exactly one cycle per read, and the host must take the data in that cycle.

Top module: `psram_async_ctrl`

## Requirements
- R1: After reset is released, `mem_ce_n_o` stays high and `req_ready_o` stays low for exactly PWRUP_CYC clock edges. At that point ready rises, with default PWRUP_CYC = 30000, which is 150 us at 200 MHz.
- R2: A request is accepted only on an edge where valid and ready are both high. Ready is low throughout every memory cycle and its recovery gap.
- R3: A read holds `mem_ce_n_o`, `mem_oe_n_o` and the selected lane strobes low, with `mem_we_n_o` high, for exactly RD_CYC cycles. The data bus is sampled on the last of those edges. `rsp_valid_o` is high for one cycle directly after that edge, which is RD_CYC+1 falling edges after the accepting edge.
- R4: A write holds `mem_ce_n_o`, `mem_we_n_o` and the selected lane strobes low, with `mem_oe_n_o` high, for exactly WR_CYC cycles. WR_CYC may not exceed WE_MAX_CYC, and no host activity lengthens the pulse.
- R5: At the end of a write, `mem_we_n_o` rises one cycle before `mem_ce_n_o` and the lane strobes rise. The write data stays driven and unchanged through that cycle.
- R6: `mem_dq_oe_o` is high only inside a write cycle. It is low during the cycle in which `mem_oe_n_o` is low and during the cycle before it.
- R7: Between two memory cycles, `mem_ce_n_o` stays high for at least REC_CYC cycles.
- R8: `mem_adv_n_o` and `mem_clk_o` are held low at all times.
- R9: Byte enable bit 0 maps to `mem_lb_n_o`, which covers bits 7:0, and bit 1 maps to `mem_ub_n_o`, which covers bits 15:8. A write changes only the enabled bytes. On a read, a byte lane that is not enabled returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release marks stable supplies |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 21 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte enables, bit 0 = low byte |
| rsp_valid_o | output | 1 | One-cycle read data strobe |
| rsp_rdata_o | output | 16 | Read data, disabled lanes zero |
| mem_clk_o | output | 1 | Memory clock, parked low |
| mem_adv_n_o | output | 1 | Address-valid strobe, held low |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_lb_n_o | output | 1 | Low byte strobe, active low |
| mem_ub_n_o | output | 1 | High byte strobe, active low |
| mem_addr_o | output | 21 | Memory address |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe_o | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 16 | Data returned by the memory |

## Verification
The hardest situation to reach is a host request that is already waiting while the controller is busy. The two cases that matter are a request raised during the long power-up hold and a read queued directly behind a write, where the data-bus turnaround and the recovery gap both apply. The stimulus raises its first request at the instant reset is released and holds it for the full hold time. After that it issues back-to-back traffic with random gaps of zero to two cycles, so that valid is often already high while ready is low. Addresses are drawn from a small pool that includes the lowest and highest words, which makes reads return partial-lane writes made earlier.

// File: rtl/psram_ctrl_pkg.sv
`timescale 1ns/1ps
package psram_ctrl_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_READ,
    SEQ_WRITE,
    SEQ_WCLOSE,
    SEQ_RECOVER
  } seq_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/psram_pwrup_timer.sv
`timescale 1ns/1ps
module psram_pwrup_timer #(
  parameter int unsigned HOLD_CYC = 30000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int unsigned CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  logic [CW-1:0] cnt_q;

  generate
    if (HOLD_CYC < 1) begin : g_bad_hold
      $error("HOLD_CYC must be at least 1");
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (!done_o) begin
      if (cnt_q == CW'(HOLD_CYC - 1)) done_o <= 1'b1;
      else                            cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R1: once the hold has expired it never re-arms before the next reset
  p_done_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

endmodule

// File: rtl/psram_cycle_seq.sv
`timescale 1ns/1ps
module psram_cycle_seq
  import psram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 21,
  parameter int unsigned LANES      = 2,
  parameter int unsigned RD_CYC     = 4,
  parameter int unsigned WR_CYC     = 3,
  parameter int unsigned REC_CYC    = 2,
  parameter int unsigned WE_MAX_CYC = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pwr_done_i,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic                  req_write_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [LANES*8-1:0]    req_wdata_i,
  input  logic [LANES-1:0]      req_be_i,
  output logic                  ce_n_o,
  output logic                  oe_n_o,
  output logic                  we_n_o,
  output logic [LANES-1:0]      lane_n_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic [LANES*8-1:0]    dq_o,
  output logic                  dq_oe_o,
  output logic                  sample_o
);
  localparam int unsigned DATA_W = LANES * 8;
  localparam int unsigned MAXC   = max3(RD_CYC, WR_CYC, REC_CYC);
  localparam int unsigned CW     = $clog2(MAXC + 1);

  generate
    if (RD_CYC < 1 || WR_CYC < 1 || REC_CYC < 1) begin : g_bad_cyc
      $error("cycle counts must be at least 1");
    end
    if (WR_CYC > WE_MAX_CYC) begin : g_bad_we
      $error("WR_CYC exceeds WE_MAX_CYC");
    end
  endgenerate

  seq_state_e          state_q;
  logic [CW-1:0]       cnt_q;
  logic                ce_n_q, oe_n_q, we_n_q, dq_oe_q;
  logic [LANES-1:0]    lane_n_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   dq_q;
  logic                take;
  logic                cnt_zero;

  assign req_ready_o = pwr_done_i && (state_q == SEQ_IDLE);
  assign take        = req_valid_i && req_ready_o;
  assign cnt_zero    = (cnt_q == '0);
  assign sample_o    = (state_q == SEQ_READ) && cnt_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_IDLE;
      cnt_q    <= '0;
      ce_n_q   <= 1'b1;
      oe_n_q   <= 1'b1;
      we_n_q   <= 1'b1;
      lane_n_q <= '1;
      addr_q   <= '0;
      dq_q     <= '0;
      dq_oe_q  <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (take) begin
            addr_q   <= req_addr_i;
            lane_n_q <= ~req_be_i;
            ce_n_q   <= 1'b0;
            if (req_write_i) begin
              state_q <= SEQ_WRITE;
              we_n_q  <= 1'b0;
              dq_q    <= req_wdata_i;
              dq_oe_q <= 1'b1;
              cnt_q   <= CW'(WR_CYC - 1);
            end else begin
              state_q <= SEQ_READ;
              oe_n_q  <= 1'b0;
              cnt_q   <= CW'(RD_CYC - 1);
            end
          end
        end
        SEQ_READ: begin
          if (cnt_zero) begin
            ce_n_q   <= 1'b1;
            oe_n_q   <= 1'b1;
            lane_n_q <= '1;
            state_q  <= SEQ_RECOVER;
            cnt_q    <= CW'(REC_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SEQ_WRITE: begin
          if (cnt_zero) begin
            we_n_q  <= 1'b1;
            state_q <= SEQ_WCLOSE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SEQ_WCLOSE: begin
          ce_n_q   <= 1'b1;
          lane_n_q <= '1;
          dq_oe_q  <= 1'b0;
          state_q  <= SEQ_RECOVER;
          cnt_q    <= CW'(REC_CYC - 1);
        end
        SEQ_RECOVER: begin
          if (cnt_zero) state_q <= SEQ_IDLE;
          else          cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign ce_n_o   = ce_n_q;
  assign oe_n_o   = oe_n_q;
  assign we_n_o   = we_n_q;
  assign lane_n_o = lane_n_q;
  assign addr_o   = addr_q;
  assign dq_o     = dq_q;
  assign dq_oe_o  = dq_oe_q;

  // Checker counters for the pulse-width and gap windows
  logic [15:0] we_lo_q;
  logic [15:0] ce_hi_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_q <= '0;
      ce_hi_q <= 16'hFFFF;
    end else begin
      we_lo_q <= we_n_q ? 16'd0 : ((we_lo_q == 16'hFFFF) ? we_lo_q : we_lo_q + 16'd1);
      ce_hi_q <= !ce_n_q ? 16'd0 : ((ce_hi_q == 16'hFFFF) ? ce_hi_q : ce_hi_q + 16'd1);
    end
  end

  // R4: the write-enable low pulse never exceeds the maximum assert time
  p_we_max_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_q |-> (we_lo_q < 16'(WE_MAX_CYC)));

  // R5: chip enable only rises after write enable was already high
  p_we_before_ce_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ce_n_q) |-> $past(we_n_q));

  // R5: write data does not move while write enable is low
  p_wdata_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_n_q && $past(!we_n_q)) |-> ($stable(dq_q) && dq_oe_q));

  // R7: every new cycle follows a long enough chip-enable high gap
  p_rec_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ce_n_q) |-> (ce_hi_q >= 16'(REC_CYC)));

endmodule

// File: rtl/psram_rd_capture.sv
`timescale 1ns/1ps
module psram_rd_capture #(
  parameter int unsigned LANES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sample_i,
  input  logic [LANES-1:0]     lane_n_i,
  input  logic [LANES*8-1:0]   dq_i,
  output logic [LANES*8-1:0]   rdata_o,
  output logic                 rvalid_o
);
  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       rdata_o[l*8 +: 8] <= 8'h00;
        else if (sample_i) rdata_o[l*8 +: 8] <= lane_n_i[l] ? 8'h00 : dq_i[l*8 +: 8];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_o <= 1'b0;
    else         rvalid_o <= sample_i;
  end

  // R3: the response strobe is a single-cycle pulse
  p_rvalid_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

endmodule

// File: rtl/psram_async_ctrl.sv
`timescale 1ns/1ps
module psram_async_ctrl #(
  parameter int unsigned ADDR_W     = 21,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned PWRUP_CYC  = 30000,
  parameter int unsigned RD_CYC     = 4,
  parameter int unsigned WR_CYC     = 3,
  parameter int unsigned REC_CYC    = 2,
  parameter int unsigned WE_MAX_CYC = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W/8-1:0] req_be_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              mem_clk_o,
  output logic              mem_adv_n_o,
  output logic              mem_ce_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic              mem_lb_n_o,
  output logic              mem_ub_n_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned LANES = DATA_W / 8;

  generate
    if (LANES != 2) begin : g_bad_width
      $error("two byte-lane strobes require DATA_W of 16");
    end
  endgenerate

  logic             pwr_done;
  logic             sample;
  logic [LANES-1:0] lane_n;

  psram_pwrup_timer #(.HOLD_CYC(PWRUP_CYC)) u_pwrup (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_o (pwr_done)
  );

  psram_cycle_seq #(
    .ADDR_W(ADDR_W), .LANES(LANES), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC),
    .REC_CYC(REC_CYC), .WE_MAX_CYC(WE_MAX_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_done_i  (pwr_done),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_be_i    (req_be_i),
    .ce_n_o      (mem_ce_n_o),
    .oe_n_o      (mem_oe_n_o),
    .we_n_o      (mem_we_n_o),
    .lane_n_o    (lane_n),
    .addr_o      (mem_addr_o),
    .dq_o        (mem_dq_o),
    .dq_oe_o     (mem_dq_oe_o),
    .sample_o    (sample)
  );

  psram_rd_capture #(.LANES(LANES)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample),
    .lane_n_i (lane_n),
    .dq_i     (mem_dq_i),
    .rdata_o  (rsp_rdata_o),
    .rvalid_o (rsp_valid_o)
  );

  assign mem_lb_n_o  = lane_n[0];
  assign mem_ub_n_o  = lane_n[1];
  assign mem_clk_o   = 1'b0;
  assign mem_adv_n_o = 1'b0;

  // R1: no chip enable while the power-up hold is running
  p_ce_pwrup_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_done |-> mem_ce_n_o);

  // R2: no acceptance possible while a memory cycle is open
  p_ready_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_n_o |-> !req_ready_o);

  // R4: output enable and write enable are never low together
  p_oe_we_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_n_o && !mem_we_n_o));

  // R6: data bus released now and in the previous cycle whenever the memory drives
  p_dq_turn_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (!mem_dq_oe_o && !$past(mem_dq_oe_o)));

endmodule

// File: tb/psram_async_ctrl_tb.sv
`timescale 1ns/1ps
module psram_async_ctrl_tb_top;
  localparam int unsigned AW    = 21;
  localparam int unsigned PWRUP = 30000;
  localparam int unsigned RD    = 4;
  localparam int unsigned WR    = 3;
  localparam int unsigned REC   = 2;
  localparam int unsigned WEMAX = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic [1:0]    req_be = 2'b11;
  logic          req_ready, rsp_valid;
  logic [15:0]   rsp_rdata;
  logic          mem_clk, adv_n, ce_n, oe_n, we_n, lb_n, ub_n, dq_oe;
  logic [AW-1:0] mem_addr;
  logic [15:0]   dq_o;
  logic [15:0]   dq_i = 16'hxxxx;

  psram_async_ctrl #(
    .ADDR_W(AW), .DATA_W(16), .PWRUP_CYC(PWRUP), .RD_CYC(RD), .WR_CYC(WR),
    .REC_CYC(REC), .WE_MAX_CYC(WEMAX)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_be_i(req_be), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_clk_o(mem_clk), .mem_adv_n_o(adv_n), .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n),
    .mem_we_n_o(we_n), .mem_lb_n_o(lb_n), .mem_ub_n_o(ub_n), .mem_addr_o(mem_addr),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] init_val(input logic [AW-1:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  // Bench shadow of expected contents (updated at request acceptance)
  logic [15:0] shadow [int unsigned];
  function automatic logic [15:0] shadow_get(input logic [AW-1:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : init_val(a);
  endfunction

  // Memory model, written on the write-enable rising edge
  logic [15:0] mem_m [int unsigned];
  function automatic logic [15:0] mem_get(input logic [AW-1:0] a);
    return mem_m.exists(int'(a)) ? mem_m[int'(a)] : init_val(a);
  endfunction

  int v_pins = 0, v_pwr = 0, v_ow = 0, v_turn = 0, v_rdy = 0, v_rv = 0;
  int we_len = 0, oe_len = 0, ce_hi = 0, oe_cnt = 0;
  bit rdy_seen = 1'b0, had_access = 1'b0;
  logic p_we_n = 1'b1, p_oe_n = 1'b1, p_ce_n = 1'b1, p_dq_oe = 1'b0, p_rv = 1'b0;
  logic p_lb_n = 1'b1, p_ub_n = 1'b1;
  logic [15:0] p_dq = '0;
  logic [AW-1:0] p_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (adv_n !== 1'b0 || mem_clk !== 1'b0) v_pins++;
      if (!rdy_seen) begin
        if (req_ready) rdy_seen = 1'b1;
        else if (ce_n !== 1'b1) v_pwr++;
      end
      if (!oe_n && !we_n) v_ow++;
      if (!oe_n && (dq_oe || p_dq_oe)) v_turn++;
      if (dq_oe && ce_n) v_turn++;
      if (!ce_n && req_ready) v_rdy++;
      if (rsp_valid && p_rv) v_rv++;
      if (!we_n) we_len++;
      if (!oe_n) oe_len++;
      if (we_n && !p_we_n) begin
        check(we_len == WR, "R4", "write pulse length", we_len, WR);
        check(!ce_n && lb_n == p_lb_n && ub_n == p_ub_n, "R5", "ce/lanes still low at we rise",
              {ce_n, lb_n, ub_n}, {1'b0, p_lb_n, p_ub_n});
        check(dq_oe && dq_o == p_dq, "R5", "write data held at we rise", dq_o, p_dq);
        if (!p_lb_n) mem_m[int'(p_addr)] = {mem_get(p_addr)[15:8], p_dq[7:0]};
        if (!p_ub_n) mem_m[int'(p_addr)] = {p_dq[15:8], mem_get(p_addr)[7:0]};
        we_len = 0;
      end
      if (oe_n && !p_oe_n) begin
        check(oe_len == RD, "R3", "output enable low length", oe_len, RD);
        oe_len = 0;
      end
      if (ce_n && !p_ce_n) check(p_we_n == 1'b1, "R5", "we high before ce rise", p_we_n, 1);
      if (!ce_n && p_ce_n) begin
        if (had_access) check(ce_hi >= REC, "R7", "ce high gap", ce_hi, REC);
        had_access = 1'b1;
        ce_hi = 0;
      end
      if (ce_n) ce_hi++;
      oe_cnt = oe_n ? 0 : oe_cnt + 1;
      if (!ce_n && !oe_n && we_n && oe_cnt >= RD)
        dq_i = {ub_n ? 8'hzz : mem_get(mem_addr)[15:8], lb_n ? 8'hzz : mem_get(mem_addr)[7:0]};
      else
        dq_i = 16'hxxxx;
      p_we_n = we_n; p_oe_n = oe_n; p_ce_n = ce_n; p_dq_oe = dq_oe; p_rv = rsp_valid;
      p_lb_n = lb_n; p_ub_n = ub_n; p_dq = dq_o; p_addr = mem_addr;
    end
  end

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                        input logic [1:0] be);
    logic [15:0] exp;
    int lat;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    exp = shadow_get(a) & lane_mask(be);
    @(posedge clk);
    if (wr) shadow[int'(a)] = (shadow_get(a) & ~lane_mask(be)) | (d & lane_mask(be));
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R2", "ready low after acceptance", req_ready, 0);
    if (!wr) begin
      lat = 1;
      while (!rsp_valid && lat < 64) begin @(negedge clk); lat++; end
      check(lat == RD + 1, "R3", "read response latency", lat, RD + 1);
      check(rsp_rdata === exp, "R9", "read data with lane mask", rsp_rdata, exp);
    end
  endtask

  function automatic logic [AW-1:0] pick_addr();
    case ($urandom % 4)
      0: return '0;
      1: return {AW{1'b1}};
      2: return AW'($urandom % 8);
      default: return AW'($urandom);
    endcase
  endfunction

  initial begin
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(ce_n && we_n && oe_n && !dq_oe && !req_ready && !rsp_valid, "R1", "reset state",
          {ce_n, we_n, oe_n, dq_oe, req_ready, rsp_valid}, 6'b111000);
    rst_n = 1'b1;
    // request pending from the moment reset is released
    req_valid = 1'b1; req_write = 1'b1; req_addr = '0; req_wdata = 16'hA55A; req_be = 2'b11;
    n = 0;
    do begin @(negedge clk); n++; end while (!req_ready && n < PWRUP + 10);
    check(n == PWRUP, "R1", "power-up hold length", n, PWRUP);
    @(posedge clk);
    shadow[0] = 16'hA55A;
    @(negedge clk);
    req_valid = 1'b0;
    // directed corners
    do_req(1'b0, '0, '0, 2'b11);
    do_req(1'b1, {AW{1'b1}}, 16'h1234, 2'b01);
    do_req(1'b0, {AW{1'b1}}, '0, 2'b11);
    do_req(1'b1, {AW{1'b1}}, 16'hBEEF, 2'b10);
    do_req(1'b0, {AW{1'b1}}, '0, 2'b11);
    do_req(1'b0, {AW{1'b1}}, '0, 2'b01);
    do_req(1'b0, {AW{1'b1}}, '0, 2'b10);
    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [1:0] be;
      be = 2'(1 + ($urandom % 3));
      do_req(1'($urandom % 2), pick_addr(), 16'($urandom), be);
      repeat ($urandom % 3) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    check(v_pins == 0, "R8", "adv/clk parked low violations", v_pins, 0);
    check(v_pwr == 0, "R1", "ce low during power-up", v_pwr, 0);
    check(v_ow == 0, "R4", "oe and we low together", v_ow, 0);
    check(v_turn == 0, "R6", "data bus turnaround violations", v_turn, 0);
    check(v_rdy == 0, "R2", "ready high during cycle", v_rdy, 0);
    check(v_rv == 0, "R3", "response strobe longer than one cycle", v_rv, 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule